// File: doc/BRIEF.md
# Pipeline Hazard Stall and Bubble Control

This block is the combinational hazard controller of a five-stage in-order pipeline. It runs every cycle. It looks at the instruction codes in the decode, execute and memory stages, at the register the execute-stage instruction will load, at the two source registers the decode stage reads, and at the condition the execute stage computed for a jump. From these it decides whether the fetch and decode pipeline registers hold their contents on the next edge. It also decides whether the decode and execute pipeline registers are loaded with a bubble, which is a no-operation.

The block recognises three hazard classes.

- **Load followed by use.** The consumer is held for one cycle so that the loaded value can later be forwarded from the memory stage.
- **Wrongly predicted conditional jump.** Jumps are always predicted taken. When the prediction proves wrong, the two wrongly fetched instructions are squashed.
- **Return instruction in flight.** Fetch waits until the return address is known.

When two classes occur together, a fixed priority applies. A pipeline register is never told to stall and to take a bubble in the same cycle. The instruction encoding is held in a shared package:

| Code | Meaning |
|------|---------|
| 5 | memory load |
| 11 | pop |
| 7 | jump |
| 9 | return |
| 1 | no-operation |

Register ID 15 means "no register".

Top module: `pipeHazardCtl`

## Requirements
- R1: When the execute code is 5 (load) or 11 (pop) and exeLoadDst equals decSrcA or decSrcB, the outputs {fetchStall, decStall, decBubble, exeBubble} are 1,1,0,1.
- R2: An exeLoadDst of 15 (no register) never raises a load/use hazard, even when a decode source is also 15.
- R3: When the execute code is 7 (jump) and exeCondOk is 0, the outputs are fetchStall 0, decStall 0, decBubble 1, exeBubble 1.
- R4: A jump in execute with exeCondOk 1 causes no stall and no bubble by itself.
- R5: When code 9 (return) is in decode, execute or memory, and there is neither a load/use hazard nor a mispredict, the outputs are fetchStall 1, decStall 0, decBubble 1, exeBubble 0.
- R6: decStall and decBubble are never both 1.
- R7: A load/use hazard together with a return in decode gives fetchStall 1, decStall 1, decBubble 0, exeBubble 1.
- R8: A mispredict together with a return in decode or memory gives fetchStall 0, decStall 0, decBubble 1, exeBubble 1.
- R9: With no hazard condition, all four outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| decIcode | input | 4 | instruction code in decode |
| exeIcode | input | 4 | instruction code in execute |
| memIcode | input | 4 | instruction code in memory |
| exeLoadDst | input | 4 | register the execute instruction loads from memory |
| decSrcA | input | 4 | first source register read in decode |
| decSrcB | input | 4 | second source register read in decode |
| exeCondOk | input | 1 | jump condition evaluated in execute is true |
| fetchStall | output | 1 | hold the fetch register |
| decStall | output | 1 | hold the decode register |
| decBubble | output | 1 | load a no-operation into decode |
| exeBubble | output | 1 | load a no-operation into execute |

## Verification
Directed patterns cover each hazard on its own:

- a load or a pop matching either source, which separates the A-side and B-side compares;
- a jump with its condition false and with it true, which separates a mispredict from a correct prediction;
- a return placed in each of the three stages in turn.

Further directed patterns cover the two overlapping cases and the destination 15. The destination 15 separates a real match from a match on the "no register" ID. Random mixes of codes and register IDs then compare all four outputs against an independent bench model. These mixes reach the combinations the directed cases leave out, such as a load whose destination matches both sources while a return sits in memory.

// File: rtl/pipeHazardPkg.sv
package pipeHazardPkg;
  localparam int ICODE_W = 4;
  localparam int REG_W   = 4;

  localparam logic [ICODE_W-1:0] OP_NOP  = ICODE_W'(1);
  localparam logic [ICODE_W-1:0] OP_LOAD = ICODE_W'(5);
  localparam logic [ICODE_W-1:0] OP_JXX  = ICODE_W'(7);
  localparam logic [ICODE_W-1:0] OP_RET  = ICODE_W'(9);
  localparam logic [ICODE_W-1:0] OP_POP  = ICODE_W'(11);

  localparam logic [REG_W-1:0] REG_NONE = {REG_W{1'b1}};

  // strobes from the detector to the arbiter
  typedef struct packed {
    logic loadUse;
    logic mispredict;
    logic retActive;
  } hazStrobes_t;

  // per-stage pipeline register control
  typedef struct packed {
    logic fetchStall;
    logic decStall;
    logic decBubble;
    logic exeBubble;
  } stageCtl_t;
endpackage

// File: rtl/hazDetect.sv
module hazDetect
  import pipeHazardPkg::*;
#(
  parameter int IW = ICODE_W,
  parameter int RW = REG_W
) (
  input  logic [IW-1:0] decIcode,
  input  logic [IW-1:0] exeIcode,
  input  logic [IW-1:0] memIcode,
  input  logic [RW-1:0] exeLoadDst,
  input  logic [RW-1:0] decSrcA,
  input  logic [RW-1:0] decSrcB,
  input  logic          exeCondOk,
  output hazStrobes_t   strobes
);
  localparam int NUM_SRC = 2;
  localparam int NUM_RET_STAGES = 3;

  logic [RW-1:0] srcIds [NUM_SRC];
  logic [IW-1:0] stageCodes [NUM_RET_STAGES];
  logic [NUM_SRC-1:0] srcHit;
  logic [NUM_RET_STAGES-1:0] retHit;
  logic exeIsLoad;
  logic dstReal;

  assign srcIds[0] = decSrcA;
  assign srcIds[1] = decSrcB;
  assign stageCodes[0] = decIcode;
  assign stageCodes[1] = exeIcode;
  assign stageCodes[2] = memIcode;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    assign srcHit[s] = (srcIds[s] == exeLoadDst);
  end

  for (genvar g = 0; g < NUM_RET_STAGES; g++) begin : g_ret
    assign retHit[g] = (stageCodes[g] == IW'(OP_RET));
  end

  assign exeIsLoad = (exeIcode == IW'(OP_LOAD)) || (exeIcode == IW'(OP_POP));
  assign dstReal   = (exeLoadDst != RW'(REG_NONE));

  always_comb begin
    strobes.loadUse    = exeIsLoad && dstReal && (|srcHit);
    strobes.mispredict = (exeIcode == IW'(OP_JXX)) && !exeCondOk;
    strobes.retActive  = |retHit;
  end
endmodule

// File: rtl/hazArbiter.sv
module hazArbiter
  import pipeHazardPkg::*;
(
  input  hazStrobes_t strobes,
  output stageCtl_t   ctl
);
  always_comb begin
    ctl = '0;
    if (strobes.mispredict) begin
      // squash the two wrong-path instructions; fetch redirects
      ctl.decBubble = 1'b1;
      ctl.exeBubble = 1'b1;
    end else begin
      if (strobes.retActive) begin
        ctl.fetchStall = 1'b1;
        ctl.decBubble  = 1'b1;
      end
      if (strobes.loadUse) begin
        // decode must hold: a hold overrides the return bubble
        ctl.fetchStall = 1'b1;
        ctl.decStall   = 1'b1;
        ctl.decBubble  = 1'b0;
        ctl.exeBubble  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pipeHazardCtl.sv
module pipeHazardCtl
  import pipeHazardPkg::*;
(
  input  logic [ICODE_W-1:0] decIcode,
  input  logic [ICODE_W-1:0] exeIcode,
  input  logic [ICODE_W-1:0] memIcode,
  input  logic [REG_W-1:0]   exeLoadDst,
  input  logic [REG_W-1:0]   decSrcA,
  input  logic [REG_W-1:0]   decSrcB,
  input  logic               exeCondOk,
  output logic               fetchStall,
  output logic               decStall,
  output logic               decBubble,
  output logic               exeBubble
);
  hazStrobes_t strobes;
  stageCtl_t   ctl;

  hazDetect #(.IW(ICODE_W), .RW(REG_W)) u_detect (
    .decIcode  (decIcode),
    .exeIcode  (exeIcode),
    .memIcode  (memIcode),
    .exeLoadDst(exeLoadDst),
    .decSrcA   (decSrcA),
    .decSrcB   (decSrcB),
    .exeCondOk (exeCondOk),
    .strobes   (strobes)
  );

  hazArbiter u_arb (
    .strobes(strobes),
    .ctl    (ctl)
  );

  assign fetchStall = ctl.fetchStall;
  assign decStall   = ctl.decStall;
  assign decBubble  = ctl.decBubble;
  assign exeBubble  = ctl.exeBubble;
endmodule

// File: rtl/pipeHazardChk.sv
module pipeHazardChk
  import pipeHazardPkg::*;
(
  input logic [ICODE_W-1:0] decIcode,
  input logic [ICODE_W-1:0] exeIcode,
  input logic [ICODE_W-1:0] memIcode,
  input logic [REG_W-1:0]   exeLoadDst,
  input logic [REG_W-1:0]   decSrcA,
  input logic [REG_W-1:0]   decSrcB,
  input logic               exeCondOk,
  input logic               fetchStall,
  input logic               decStall,
  input logic               decBubble,
  input logic               exeBubble
);
  logic known;
  logic isLd;
  logic match;
  logic isMisp;
  logic anyRet;

  always_comb begin
    known  = !$isunknown({decIcode, exeIcode, memIcode, exeLoadDst,
                          decSrcA, decSrcB, exeCondOk});
    isLd   = (exeIcode == OP_LOAD) || (exeIcode == OP_POP);
    match  = (exeLoadDst != REG_NONE) &&
             ((exeLoadDst == decSrcA) || (exeLoadDst == decSrcB));
    isMisp = (exeIcode == OP_JXX) && !exeCondOk;
    anyRet = (decIcode == OP_RET) || (exeIcode == OP_RET) || (memIcode == OP_RET);

    if (known) begin
      p_dec_excl_r6: assert (!(decStall && decBubble));
      if (isLd && match)
        p_loaduse_r1: assert (fetchStall && decStall && !decBubble && exeBubble);
      if (exeLoadDst == REG_NONE)
        p_nodst_r2: assert (!decStall);
      if (isMisp)
        p_misp_r3: assert (!fetchStall && !decStall && decBubble && exeBubble);
      if (anyRet && !isMisp && !(isLd && match))
        p_ret_r5: assert (fetchStall && !decStall && decBubble && !exeBubble);
      if (!anyRet && !isMisp && !(isLd && match))
        p_idle_r9: assert (!fetchStall && !decStall && !decBubble && !exeBubble);
    end
  end
endmodule

bind pipeHazardCtl pipeHazardChk u_chk (.*);

// File: tb/pipeHazardCtl_bench.sv
`timescale 1ns/1ps
module pipeHazardCtl_bench;
  import pipeHazardPkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic [3:0] decIcode, exeIcode, memIcode, exeLoadDst, decSrcA, decSrcB;
  logic exeCondOk;
  logic fetchStall, decStall, decBubble, exeBubble;

  int nChecks = 0;
  int nFails = 0;
  int cycles = 0;
  bit done = 1'b0;

  pipeHazardCtl u_pipeHazardCtl (.*);

  // bench model: {fetchStall, decStall, decBubble, exeBubble}
  function automatic logic [3:0] model(input logic [3:0] d, e, m, dst, a, b,
                                       input logic ok);
    bit lu = ((e == 4'd5) || (e == 4'd11)) && (dst != 4'd15) && (dst == a || dst == b);
    bit mp = (e == 4'd7) && !ok;
    bit rt = (d == 4'd9) || (e == 4'd9) || (m == 4'd9);
    if (mp) return 4'b0011;   // R3, R8
    if (lu) return 4'b1101;   // R1, R7
    if (rt) return 4'b1010;   // R5
    return 4'b0000;           // R9
  endfunction

  task automatic apply(input logic [3:0] d, e, m, dst, a, b, input logic ok,
                       input string tag);
    logic [3:0] exp;
    logic [3:0] got;
    @(posedge clk);
    decIcode = d; exeIcode = e; memIcode = m;
    exeLoadDst = dst; decSrcA = a; decSrcB = b; exeCondOk = ok;
    @(negedge clk);
    exp = model(d, e, m, dst, a, b, ok);
    got = {fetchStall, decStall, decBubble, exeBubble};
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %b expected %b (d=%0d e=%0d m=%0d dst=%0d a=%0d b=%0d ok=%0b)",
               tag, got, exp, d, e, m, dst, a, b, ok);
    end
    if (decStall && decBubble) begin
      nChecks++; nFails++;
      $display("FAIL R6: got stall=1 bubble=1 expected not both");
    end
  endtask

  function automatic logic [3:0] pickOp(input int unsigned r);
    case (r % 6)
      0: return 4'd5;
      1: return 4'd11;
      2: return 4'd7;
      3: return 4'd9;
      4: return 4'd2;
      default: return 4'd1;
    endcase
  endfunction

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      nFails++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails + 0);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    decIcode = 4'd1; exeIcode = 4'd1; memIcode = 4'd1;
    exeLoadDst = 4'd15; decSrcA = 4'd15; decSrcB = 4'd15; exeCondOk = 1'b1;
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    apply(4'd1, 4'd1, 4'd1, 4'd15, 4'd15, 4'd15, 1'b1, "R9 reset idle");
    apply(4'd2, 4'd5, 4'd1, 4'd3, 4'd3, 4'd6, 1'b1, "R1 load srcA");
    apply(4'd2, 4'd11, 4'd1, 4'd4, 4'd0, 4'd4, 1'b1, "R1 pop srcB");
    apply(4'd2, 4'd5, 4'd1, 4'd3, 4'd2, 4'd6, 1'b1, "R9 load no match");
    apply(4'd2, 4'd5, 4'd1, 4'd15, 4'd15, 4'd15, 1'b1, "R2 none dest");
    apply(4'd2, 4'd7, 4'd1, 4'd3, 4'd3, 4'd3, 1'b0, "R3 mispredict");
    apply(4'd2, 4'd7, 4'd1, 4'd3, 4'd3, 4'd3, 1'b1, "R4 jump taken");
    apply(4'd9, 4'd1, 4'd1, 4'd15, 4'd4, 4'd15, 1'b1, "R5 ret decode");
    apply(4'd1, 4'd9, 4'd1, 4'd15, 4'd4, 4'd15, 1'b1, "R5 ret execute");
    apply(4'd1, 4'd1, 4'd9, 4'd15, 4'd4, 4'd15, 1'b1, "R5 ret memory");
    apply(4'd9, 4'd5, 4'd1, 4'd4, 4'd4, 4'd15, 1'b1, "R7 load+ret");
    apply(4'd9, 4'd7, 4'd1, 4'd15, 4'd4, 4'd15, 1'b0, "R8 misp+ret decode");
    apply(4'd1, 4'd7, 4'd9, 4'd15, 4'd4, 4'd15, 1'b0, "R8 misp+ret memory");
    apply(4'd9, 4'd7, 4'd1, 4'd15, 4'd4, 4'd15, 1'b1, "R5 R4 ret+taken jump");
    for (int i = 0; i < 400; i++) begin
      logic [3:0] d, e, m, dst, a, b;
      d = pickOp($urandom); e = pickOp($urandom); m = pickOp($urandom);
      dst = ($urandom % 5 == 0) ? 4'd15 : 4'($urandom % 4);
      a = ($urandom % 5 == 0) ? 4'd15 : 4'($urandom % 4);
      b = ($urandom % 5 == 0) ? 4'd15 : 4'($urandom % 4);
      apply(d, e, m, dst, a, b, 1'($urandom % 2), "R9 R1 R3 R5 random");
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule